// File: doc/BRIEF.md
# Link Management Control and Status Register Pair

This block holds the two 16-bit management registers that sit in front of a serial gigabit Ethernet PCS. The control word drives four signals into the PCS: a one-cycle pulse that resets its transmit, receive and negotiation sub-blocks, a loopback level, a negotiation enable level, and a one-cycle negotiation restart pulse. The status word reports link conditions that the PCS raises as plain level inputs. Some status bits are sticky and are cleared by reading them.

Access is through a plain synchronous port with address, write strobe, read strobe, write data and read data. Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Reading the status word clears its sticky bits. An event that arrives in the cycle of that read is kept for the next read.

Top module: `link_mgmt_regs`

## Requirements
- R1: A write to address 0 with bit 15 set raises `pcs_rst_pulse_o` for exactly the one cycle after the write. Bit 15 always reads back 0.
- R2: Control bit 14 is stored and drives `loopback_o` from the cycle after the write. It reads back as written.
- R3: Control bit 12 is stored and drives `an_enable_o`. Bit 9 raises `an_restart_pulse_o` for the one cycle after the write, but only if bit 12 is also set in the same write. Bit 9 always reads back 0.
- R4: After reset all control outputs are 0 and the control word reads 0x0000. Control bits 13, 11, 10 and 8 to 0 always read 0.
- R5: Status bit 4 (remote fault) sets when `rem_fault_i` is high in any cycle. It stays set until a status read. A fault that is high in the cycle of the read is kept for the next read.
- R6: Status bit 2 (link) is 0 after reset. It falls and stays 0 whenever `link_ok_i` is low, even if the link later recovers. A status read returns the held value and then reloads the bit from the live `link_ok_i`.
- R7: Status bit 5 reads `an_done_i` AND the stored negotiation enable, both sampled in the read cycle. It reads 0 whenever negotiation is disabled.
- R8: Status bits 8, 6, 3 and 0 always read 1. Bits 15 to 9, 7 and 1 always read 0. With link and fault clear, the status word is 0x0149.
- R9: Control is at address 0 and status is at address 1. A write to any address other than 0 changes no output and no register. A read from any other address returns 0.
- R10: `rdata_o` is loaded in the cycle after `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0 control, 1 status) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| link_ok_i | input | 1 | Live link-good level from the PCS |
| rem_fault_i | input | 1 | Remote fault event from the PCS |
| an_done_i | input | 1 | Negotiation finished level from the PCS |
| pcs_rst_pulse_o | output | 1 | One-cycle PCS sub-block reset |
| loopback_o | output | 1 | Loopback enable |
| an_enable_o | output | 1 | Negotiation enable |
| an_restart_pulse_o | output | 1 | One-cycle negotiation restart |

## Verification
The two functions that can meet in one cycle are the clear-on-read of the status word and the arrival of a new PCS event. The bench raises `rem_fault_i`, or drops `link_ok_i`, in exactly the cycle of a status read. It then judges that this read returns the old sticky value and that the next read shows the new event. A long random phase drives reads, writes and events together. A behavioural model compares every output on every clock, so these collisions are also judged when they occur by chance.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
   // control word fields (positions decoded by the management software)
   localparam int CTL_PCS_RST   = 15;
   localparam int CTL_LOOPBACK  = 14;
   localparam int CTL_AN_ENABLE = 12;
   localparam int CTL_AN_RESTRT = 9;
   // status word fields
   localparam int STS_EXT_STAT  = 8;
   localparam int STS_PRE_SUPP  = 6;
   localparam int STS_AN_CMPL   = 5;
   localparam int STS_RFAULT    = 4;
   localparam int STS_AN_ABLE   = 3;
   localparam int STS_LINK      = 2;
   localparam int STS_EXT_CAP   = 0;

   typedef struct packed {
      logic loopback;
      logic an_enable;
   } ctl_state_t;
endpackage

// File: rtl/lmr_ctrl_reg.sv
module lmr_ctrl_reg
   import lmr_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [REG_W-1:0] wdata,
   output logic             pcs_rst_pulse_o,
   output logic             an_restart_pulse_o,
   output ctl_state_t       state_o,
   output logic [REG_W-1:0] ctrl_word_o
);
   ctl_state_t state_q;
   logic       rst_p_q, rstrt_p_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= '0;
         rst_p_q   <= 1'b0;
         rstrt_p_q <= 1'b0;
      end else begin
         rst_p_q   <= wr_hit & wdata[CTL_PCS_RST];
         rstrt_p_q <= wr_hit & wdata[CTL_AN_RESTRT] & wdata[CTL_AN_ENABLE];
         if (wr_hit) begin
            state_q.loopback  <= wdata[CTL_LOOPBACK];
            state_q.an_enable <= wdata[CTL_AN_ENABLE];
         end
      end
   end

   always_comb begin
      ctrl_word_o                = '0;
      ctrl_word_o[CTL_LOOPBACK]  = state_q.loopback;
      ctrl_word_o[CTL_AN_ENABLE] = state_q.an_enable;
   end

   assign state_o            = state_q;
   assign pcs_rst_pulse_o    = rst_p_q;
   assign an_restart_pulse_o = rstrt_p_q;

   AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_rst_pulse_o |-> $past(wr_hit && wdata[CTL_PCS_RST])); // R1
   AST_RESTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      an_restart_pulse_o |-> state_o.an_enable); // R3
endmodule

// File: rtl/lmr_stat_reg.sv
module lmr_stat_reg
   import lmr_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_clr,
   input  logic             link_ok_i,
   input  logic             rem_fault_i,
   input  logic             an_done_i,
   input  logic             an_enable_i,
   output logic [REG_W-1:0] stat_word_o
);
   localparam logic [REG_W-1:0] CONST_ONES =
      REG_W'((1 << STS_EXT_STAT) | (1 << STS_PRE_SUPP) |
             (1 << STS_AN_ABLE) | (1 << STS_EXT_CAP));

   logic fault_q, link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         link_q  <= 1'b0;
      end else if (rd_clr) begin
         fault_q <= rem_fault_i;
         link_q  <= link_ok_i;
      end else begin
         fault_q <= fault_q | rem_fault_i;
         link_q  <= link_q & link_ok_i;
      end
   end

   always_comb begin
      stat_word_o              = CONST_ONES;
      stat_word_o[STS_AN_CMPL] = an_done_i & an_enable_i;
      stat_word_o[STS_RFAULT]  = fault_q;
      stat_word_o[STS_LINK]    = link_q;
   end

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rem_fault_i) |-> fault_q); // R5
   AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(link_ok_i) |-> !link_q); // R6
endmodule

// File: rtl/link_mgmt_regs.sv
module link_mgmt_regs
   import lmr_pkg::*;
#(
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata_o,
   input  logic              link_ok_i,
   input  logic              rem_fault_i,
   input  logic              an_done_i,
   output logic              pcs_rst_pulse_o,
   output logic              loopback_o,
   output logic              an_enable_o,
   output logic              an_restart_pulse_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   generate
      if (REG_W != 16) begin : g_bad_width
         $error("link_mgmt_regs: REG_W must be 16");
      end
      if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR >= (1 << ADDR_W) ||
          STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("link_mgmt_regs: register addresses invalid");
      end
   endgenerate

   logic             ctrl_wr, stat_rd;
   ctl_state_t       cstate;
   logic [REG_W-1:0] ctrl_word, stat_word;

   assign ctrl_wr = wr_en && (addr == A_CTRL);
   assign stat_rd = rd_en && (addr == A_STAT);

   lmr_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
      .clk                (clk),
      .rst_n              (rst_n),
      .wr_hit             (ctrl_wr),
      .wdata              (wdata),
      .pcs_rst_pulse_o    (pcs_rst_pulse_o),
      .an_restart_pulse_o (an_restart_pulse_o),
      .state_o            (cstate),
      .ctrl_word_o        (ctrl_word)
   );

   lmr_stat_reg #(.REG_W(REG_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_clr      (stat_rd),
      .link_ok_i   (link_ok_i),
      .rem_fault_i (rem_fault_i),
      .an_done_i   (an_done_i),
      .an_enable_i (cstate.an_enable),
      .stat_word_o (stat_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (rd_en) begin
         if (addr == A_CTRL)      rdata_o <= ctrl_word;
         else if (addr == A_STAT) rdata_o <= stat_word;
         else                     rdata_o <= '0;
      end
   end

   assign loopback_o  = cstate.loopback;
   assign an_enable_o = cstate.an_enable;

   AST_AN_CMPL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && addr == A_STAT && !an_enable_o) |-> !rdata_o[STS_AN_CMPL]); // R7
   AST_CONST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && addr == A_STAT) |-> (rdata_o[STS_EXT_CAP] && rdata_o[STS_AN_ABLE]
         && rdata_o[STS_PRE_SUPP] && rdata_o[STS_EXT_STAT])); // R8
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && addr != A_CTRL) |-> (!pcs_rst_pulse_o && !an_restart_pulse_o)); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(rdata_o)); // R10
endmodule

// File: tb/link_mgmt_regs_bench.sv
module link_mgmt_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata_o;
   logic        link_ok_i = 1'b1, rem_fault_i = 1'b0, an_done_i = 1'b0;
   logic        pcs_rst_pulse_o, loopback_o, an_enable_o, an_restart_pulse_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   link_mgmt_regs u_link_mgmt_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata_o(rdata_o), .link_ok_i(link_ok_i),
      .rem_fault_i(rem_fault_i), .an_done_i(an_done_i),
      .pcs_rst_pulse_o(pcs_rst_pulse_o), .loopback_o(loopback_o),
      .an_enable_o(an_enable_o), .an_restart_pulse_o(an_restart_pulse_o)
   );

   // behavioural reference model
   int m_loop, m_anen, m_rstp, m_rsp, m_fault, m_link, m_rdata;
   initial begin
      m_loop = 0; m_anen = 0; m_rstp = 0; m_rsp = 0;
      m_fault = 0; m_link = 0; m_rdata = 0;
   end

   always @(posedge clk) begin
      int sw, cw;
      if (!rst_n) begin
         m_loop = 0; m_anen = 0; m_rstp = 0; m_rsp = 0;
         m_fault = 0; m_link = 0; m_rdata = 0;
      end else begin
         cw = m_loop * 16384 + m_anen * 4096;
         sw = 256 + 64 + 8 + 1 + ((an_done_i && m_anen) ? 32 : 0)
              + m_fault * 16 + m_link * 4;
         if (rd_en) m_rdata = (addr == 0) ? cw : (addr == 1) ? sw : 0;
         if (rd_en && addr == 1) begin
            m_fault = int'(rem_fault_i);
            m_link  = int'(link_ok_i);
         end else begin
            m_fault = (m_fault != 0 || rem_fault_i) ? 1 : 0;
            m_link  = (m_link != 0 && link_ok_i) ? 1 : 0;
         end
         m_rstp = (wr_en && addr == 0 && wdata[15]) ? 1 : 0;
         m_rsp  = (wr_en && addr == 0 && wdata[9] && wdata[12]) ? 1 : 0;
         if (wr_en && addr == 0) begin
            m_loop = int'(wdata[14]);
            m_anen = int'(wdata[12]);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 model pcs_rst", int'(pcs_rst_pulse_o), m_rstp);
         chk("R2 model loopback", int'(loopback_o), m_loop);
         chk("R3 model an_enable", int'(an_enable_o), m_anen);
         chk("R3 model restart", int'(an_restart_pulse_o), m_rsp);
         chk("R10 model rdata", int'(rdata_o), m_rdata);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; v = int'(rdata_o);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      finish_run();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset outputs", {pcs_rst_pulse_o, loopback_o, an_enable_o, an_restart_pulse_o}, 0);
      rd(2'd0, v); chk("R4 reset control word", v, 16'h0000);
      rd(2'd1, v); chk("R6 R8 reset status link low", v, 16'h0149);
      rd(2'd1, v); chk("R6 link reloads after read", v, 16'h014D);

      // R1 R3 all ones write
      @(negedge clk); addr = 2'd0; wdata = 16'hFFFF; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      chk("R1 reset pulse high", int'(pcs_rst_pulse_o), 1);
      chk("R3 restart pulse high", int'(an_restart_pulse_o), 1);
      @(negedge clk);
      chk("R1 reset pulse one cycle", int'(pcs_rst_pulse_o), 0);
      chk("R3 restart pulse one cycle", int'(an_restart_pulse_o), 0);
      rd(2'd0, v); chk("R2 R4 control readback", v, 16'h5000);

      // restart without enable
      @(negedge clk); addr = 2'd0; wdata = 16'h0200; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      chk("R3 restart gated by enable", int'(an_restart_pulse_o), 0);
      chk("R2 loopback cleared", int'(loopback_o), 0);

      // R7 negotiation complete
      an_done_i = 1'b1;
      rd(2'd1, v); chk("R7 complete masked when disabled", v & 16'h0020, 0);
      wr(2'd0, 16'h1000);
      rd(2'd1, v); chk("R7 complete when enabled", v & 16'h0020, 16'h0020);

      // R5 fault latch
      @(negedge clk); rem_fault_i = 1'b1;
      @(negedge clk); rem_fault_i = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd1, v); chk("R5 fault latched", v & 16'h0010, 16'h0010);
      rd(2'd1, v); chk("R5 fault cleared by read", v & 16'h0010, 0);
      @(negedge clk); addr = 2'd1; rd_en = 1'b1; rem_fault_i = 1'b1;
      @(negedge clk); rd_en = 1'b0; rem_fault_i = 1'b0; v = int'(rdata_o);
      chk("R5 read during fault returns old", v & 16'h0010, 0);
      rd(2'd1, v); chk("R5 fault in read cycle kept", v & 16'h0010, 16'h0010);

      // R6 link latch low
      @(negedge clk); link_ok_i = 1'b0;
      @(negedge clk); link_ok_i = 1'b1;
      rd(2'd1, v); chk("R6 link held low after recovery", v & 16'h0004, 0);
      rd(2'd1, v); chk("R6 link reloaded", v & 16'h0004, 16'h0004);
      @(negedge clk); addr = 2'd1; rd_en = 1'b1; link_ok_i = 1'b0;
      @(negedge clk); rd_en = 1'b0; link_ok_i = 1'b1; v = int'(rdata_o);
      chk("R6 read during drop returns old", v & 16'h0004, 16'h0004);
      rd(2'd1, v); chk("R6 drop in read cycle kept", v & 16'h0004, 0);

      // R9 address decode
      wr(2'd1, 16'hFFFF);
      chk("R9 status write no pulse", {pcs_rst_pulse_o, an_restart_pulse_o}, 0);
      wr(2'd3, 16'hFFFF);
      rd(2'd0, v); chk("R9 status write ignored", v, 16'h1000);
      rd(2'd2, v); chk("R9 unmapped read zero", v, 0);
      rd(2'd0, v);
      repeat (3) @(negedge clk);
      chk("R10 rdata holds", int'(rdata_o), 16'h1000);

      // random phase, judged by the per-clock model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         addr        = 2'($urandom_range(0, 3));
         wr_en       = ($urandom_range(0, 3) == 0);
         rd_en       = ($urandom_range(0, 1) == 0);
         wdata       = 16'($urandom);
         link_ok_i   = ($urandom_range(0, 7) != 0);
         rem_fault_i = ($urandom_range(0, 9) == 0);
         an_done_i   = ($urandom_range(0, 1) == 0);
      end
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule